// File: doc/BRIEF.md
# Quadrature Position Decoder with Wrap Cascade Output

This block turns the two phase-shifted square-wave channels of an incremental shaft encoder into position steps. The channels are first brought into the clock domain by a two-flop synchroniser. A small state machine then follows the four-phase pattern of the channel pair. Each legal move of one phase forward or back becomes one step. A step adjusts an up/down position counter of parameterised width (12 or 16 bits).

For each step the block emits a single-cycle `step_pulse`. It also drives a `dir_up` level that already holds the direction of that step one cycle before the pulse, so a downstream counter can use the pulse edge as its clock enable. When the position counter rolls over from all-ones to zero, or rolls under from zero to all-ones, `wrap_pulse` fires in the same cycle as the step pulse. An external counter can chain on it to extend the range.

The decoder state machine has four states, named after the synchronised channel pair written {B,A}: `PH_00`, `PH_01`, `PH_11` and `PH_10`. From any state there are four kinds of transition:
- `MOVE_FWD`: the pair takes the next value of the up sequence.
- `MOVE_BACK`: the pair takes the previous value.
- `HOLD`: the pair is unchanged.
- `SKIP`: both channels changed at once.

The state always follows the sampled pair.

Top module: `quad_cascade_counter`

## Requirements
- R1: The channel inputs pass through two synchronising flops. After a legal change of one channel, `step_pulse` is high in the cycle that follows the fourth rising clock edge after the change.
- R2: With the channel pair written {B,A}, the sequence 00→01→11→10→00 is forward. Each forward move adds one to `position`, in the same cycle that `step_pulse` is high.
- R3: The reverse sequence 00→10→11→01→00 subtracts one from `position` per move. `position` does not change in any cycle in which `step_pulse` is low.
- R4: Each legal move gives exactly one high cycle of `step_pulse`. A change of both channels at once (`SKIP`) and an unchanged pair (`HOLD`) give no pulse and leave `position` unchanged.
- R5: `dir_up` is 1 for a forward step and 0 for a backward step. It takes its new value one clock cycle before the matching `step_pulse` and holds it until the next step. Its reset value is 1.
- R6: `wrap_pulse` is high for one cycle, together with `step_pulse`, when `position` goes from all-ones to zero on a forward step or from zero to all-ones on a backward step. It is low at all other times.
- R7: `position` is CNT_W bits wide, with CNT_W equal to 12 or 16, and wraps modulo 2^CNT_W.
- R8: An active-low asynchronous reset immediately clears `position` to zero, drives both pulses low, sets `dir_up` to 1 and puts the decoder in state `PH_00`.
- R9: A legal move may arrive on every clock cycle. Each one is counted, with no step lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a | input | 1 | Encoder channel A, asynchronous |
| ch_b | input | 1 | Encoder channel B, asynchronous |
| position | output | CNT_W | Up/down position count |
| step_pulse | output | 1 | One-cycle pulse per decoded step |
| dir_up | output | 1 | Direction level: 1 forward, 0 backward |
| wrap_pulse | output | 1 | One-cycle pulse on overflow or underflow |

## Verification
A wrong decoder state shows at the ports within five clock edges of the next channel change, in one of three ways: a missing `step_pulse`, a spurious one, or a `dir_up` of the wrong sense. After that, `position` stays offset from the arithmetic count of applied moves. A wrong boundary in the counter shows only at the rollover, as a missing or misplaced `wrap_pulse`. For that reason the bench sweeps the whole 12-bit range in both directions at one move per cycle, and compares the final count and the pulse totals with values computed from the number of moves driven.

// File: rtl/quad_pkg.sv
`timescale 1ns/1ps
package quad_pkg;

    // Decoder states named after the synchronised {B,A} channel pair
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_t;

    // Kind of transition seen between two samples
    typedef enum logic [1:0] {
        HOLD      = 2'd0,
        MOVE_FWD  = 2'd1,
        MOVE_BACK = 2'd2,
        SKIP      = 2'd3
    } move_t;

    function automatic phase_t phase_ahead(input phase_t p);
        phase_t n;
        unique case (p)
            PH_00: n = PH_01;
            PH_01: n = PH_11;
            PH_11: n = PH_10;
            PH_10: n = PH_00;
        endcase
        return n;
    endfunction

    function automatic phase_t phase_behind(input phase_t p);
        phase_t n;
        unique case (p)
            PH_00: n = PH_10;
            PH_10: n = PH_11;
            PH_11: n = PH_01;
            PH_01: n = PH_00;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/quad_sync.sv
`timescale 1ns/1ps
module quad_sync #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_in,
    output logic [LANES-1:0] sync_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
            end
        end
        assign sync_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/quad_phase_fsm.sv
`timescale 1ns/1ps
module quad_phase_fsm
    import quad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pair_ba,
    output logic       evt_valid,
    output logic       evt_up,
    output logic       dir_up
);

    phase_t state;
    phase_t sampled;
    move_t  move;

    assign sampled = phase_t'(pair_ba);

    // Classify the transition from the held state to the new sample
    always_comb begin
        if (sampled == state) begin
            move = HOLD;
        end else if (sampled == phase_ahead(state)) begin
            move = MOVE_FWD;
        end else if (sampled == phase_behind(state)) begin
            move = MOVE_BACK;
        end else begin
            move = SKIP;
        end
    end

    // State register: always follows the sampled pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_00;
        end else begin
            state <= sampled;
        end
    end

    // Output register: event one cycle ahead of the counter stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_up    <= 1'b1;
            dir_up    <= 1'b1;
        end else begin
            unique case (move)
                MOVE_FWD: begin
                    evt_valid <= 1'b1;
                    evt_up    <= 1'b1;
                    dir_up    <= 1'b1;
                end
                MOVE_BACK: begin
                    evt_valid <= 1'b1;
                    evt_up    <= 1'b0;
                    dir_up    <= 1'b0;
                end
                HOLD, SKIP: begin
                    evt_valid <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             evt_up,
    output logic [CNT_W-1:0] position,
    output logic             step_pulse,
    output logic             wrap_pulse
);

    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic at_edge;

    assign at_edge = evt_up ? (position == TOP) : (position == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            position   <= '0;
            step_pulse <= 1'b0;
            wrap_pulse <= 1'b0;
        end else begin
            step_pulse <= evt_valid;
            wrap_pulse <= evt_valid && at_edge;
            if (evt_valid) begin
                position <= evt_up ? position + ONE : position - ONE;
            end
        end
    end

endmodule

// File: rtl/quad_cascade_counter.sv
`timescale 1ns/1ps
module quad_cascade_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_a,
    input  logic             ch_b,
    output logic [CNT_W-1:0] position,
    output logic             step_pulse,
    output logic             dir_up,
    output logic             wrap_pulse
);

    logic [1:0] pair_ba;
    logic       evt_valid;
    logic       evt_up;

    quad_sync #(.LANES(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ch_b, ch_a}),
        .sync_out (pair_ba)
    );

    quad_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_ba   (pair_ba),
        .evt_valid (evt_valid),
        .evt_up    (evt_up),
        .dir_up    (dir_up)
    );

    quad_pos_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_up     (evt_up),
        .position   (position),
        .step_pulse (step_pulse),
        .wrap_pulse (wrap_pulse)
    );

endmodule

// File: rtl/quad_cascade_checker.sv
`timescale 1ns/1ps
module quad_cascade_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] position,
    input logic             step_pulse,
    input logic             dir_up,
    input logic             wrap_pulse
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_fwd_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && dir_up) |-> (position == $past(position) + CNT_W'(1)));

    p_back_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !dir_up) |-> (position == $past(position) - CNT_W'(1)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |-> $stable(position));

    p_dir_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $stable(dir_up));

    p_wrap_with_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> step_pulse);

    p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && dir_up) |-> (wrap_pulse == (position == '0)));

    p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !dir_up) |-> (wrap_pulse == (position == TOP)));

endmodule

bind quad_cascade_counter quad_cascade_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .position   (position),
    .step_pulse (step_pulse),
    .dir_up     (dir_up),
    .wrap_pulse (wrap_pulse)
);

// File: tb/tb_quad_cascade_counter.sv
`timescale 1ns/1ps
module tb_quad_cascade_counter;

    localparam int W    = 12;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ch_a = 1'b0;
    logic         ch_b = 1'b0;
    logic [W-1:0] position;
    logic         step_pulse;
    logic         dir_up;
    logic         wrap_pulse;

    quad_cascade_counter #(.CNT_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_a       (ch_a),
        .ch_b       (ch_b),
        .position   (position),
        .step_pulse (step_pulse),
        .dir_up     (dir_up),
        .wrap_pulse (wrap_pulse)
    );

    always #2.5 clk = ~clk;

    int  total = 0;
    int  bad = 0;
    int  ph = 0;
    int  exp_pos = 0;
    bit  exp_dir = 1'b1;
    int  steps_seen = 0;
    int  wraps_seen = 0;
    int  dir_err = 0;
    bit  dir_prev = 1'b1;
    bit  finished = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (step_pulse) begin
                steps_seen++;
                if (dir_up != exp_dir || dir_up != dir_prev) dir_err++;
            end
            if (wrap_pulse) wraps_seen++;
        end
        dir_prev = dir_up;
    end

    task automatic drive_phase(input int idx);
        logic [1:0] i2;
        i2 = idx[1:0];
        ch_b = i2[1];
        ch_a = i2[1] ^ i2[0];
    endtask

    task automatic move(input bit up);
        exp_dir = up;
        ph = (ph + (up ? 1 : 3)) % 4;
        exp_pos = (exp_pos + (up ? 1 : SPAN - 1)) % SPAN;
        drive_phase(ph);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        int s0, w0, lat, width;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset position", int'(position), 0);
        check("R8 reset step_pulse", int'(step_pulse), 0);
        check("R8 reset wrap_pulse", int'(wrap_pulse), 0);
        check("R5 reset dir_up", int'(dir_up), 1);
        rst_n = 1'b1;
        settle();

        // R1 latency and R4 single-cycle width, R2 forward step
        s0 = steps_seen;
        move(1'b1);
        lat = 0;
        width = 0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (step_pulse) begin
                if (lat == 0) lat = n;
                width++;
            end
        end
        check("R1 step latency in edges", lat, 4);
        check("R4 pulse width", width, 1);
        check("R2 forward position", int'(position), exp_pos);
        check("R5 dir_up forward", int'(dir_up), 1);

        // R3 backward step
        move(1'b0);
        settle();
        check("R3 backward position", int'(position), exp_pos);
        check("R5 dir_up backward", int'(dir_up), 0);

        // R6 underflow from zero
        w0 = wraps_seen;
        move(1'b0);
        settle();
        check("R6 underflow position", int'(position), SPAN - 1);
        check("R6 underflow wrap count", wraps_seen - w0, 1);

        // R6 overflow from all-ones
        w0 = wraps_seen;
        move(1'b1);
        settle();
        check("R6 overflow position", int'(position), 0);
        check("R6 overflow wrap count", wraps_seen - w0, 1);

        // R4 both channels change at once: skipped
        s0 = steps_seen;
        move(1'b1);
        settle();
        s0 = steps_seen;
        exp_pos = int'(position);
        ph = (ph + 2) % 4;
        drive_phase(ph);
        settle();
        check("R4 skip no pulse", steps_seen - s0, 0);
        check("R4 skip position", int'(position), exp_pos);

        // R4 hold: no change for a while
        repeat (20) @(negedge clk);
        check("R4 hold no pulse", steps_seen - s0, 0);

        // R2 R3 alternating direction with waits
        for (int k = 0; k < 12; k++) begin
            move(k % 3 != 0);
            settle();
            check("R5 alternating position", int'(position), exp_pos);
        end

        // R9 R7 full forward sweep, one move per cycle
        s0 = steps_seen;
        w0 = wraps_seen;
        for (int k = 0; k < SPAN; k++) begin
            move(1'b1);
            @(negedge clk);
        end
        settle();
        check("R9 forward sweep steps", steps_seen - s0, SPAN);
        check("R7 forward sweep wraps", wraps_seen - w0, 1);
        check("R7 forward sweep position", int'(position), exp_pos);

        // R9 R7 full backward sweep
        s0 = steps_seen;
        w0 = wraps_seen;
        for (int k = 0; k < SPAN + 5; k++) begin
            move(1'b0);
            @(negedge clk);
        end
        settle();
        check("R9 backward sweep steps", steps_seen - s0, SPAN + 5);
        check("R7 backward sweep wraps", wraps_seen - w0, 1);
        check("R7 backward sweep position", int'(position), exp_pos);

        check("R5 dir valid before every pulse", dir_err, 0);

        // R8 asynchronous reset, seen before any clock edge
        move(1'b1);
        settle();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async clear position", int'(position), 0);
        check("R8 async dir_up", int'(dir_up), 1);
        ch_a = 1'b0;
        ch_b = 1'b0;
        ph = 0;
        exp_pos = 0;
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R8 after release position", int'(position), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule